// File: doc/BRIEF.md
# General-Purpose I/O Register Bank

This block is a 32-bit general-purpose I/O register bank attached to a simple bus with byte offsets, a read strobe and a write strobe. It keeps three registers: a pin level register, a direction register and a spare auxiliary register. The level register drives the pins. Each bit of the direction register turns on the output driver of the pin with the same index.

Software never writes the level register directly. A set word ORs bits into it and a clear word removes bits from it. Each of these two writes is applied in full, or dropped in full. The test is whether the written word shares at least one bit with the direction register. An accepted word also changes level bits whose pins are inputs. A dropped word raises a one-cycle error pulse.

The edge-control offsets take writes and ignore them. The nine interrupt lines are always held inactive.

Top module: `gpio_regbank`

## Requirements
- R1: When reset is asserted, the level register, the direction register, the read data and the error pulse all clear to zero. The auxiliary register keeps its value through reset.
- R2: The direction register is read and written at offset 0x04. `pin_oe` equals the direction register, where a 1 means output.
- R3: `pin_out` equals the level register. The level register is read at offset 0x00.
- R4: A write to offset 0x08 sets `level = level | value`, provided `direction & value` is nonzero. All written bits are applied, including bits of input pins.
- R5: A write to offset 0x0C sets `level = level & ~value`, provided `direction & value` is nonzero. All written bits are applied, including bits of input pins.
- R6: A set or clear write whose value has no bit in common with the direction register leaves the level register unchanged. A zero value is one such case. In the cycle after the write, `wr_err` is high for exactly one cycle.
- R7: Writes to offsets 0x10, 0x14 and 0x18, and to any offset that is not decoded, change no register.
- R8: The auxiliary register is read and written at offset 0x20.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. A read of any offset other than 0x00, 0x04 or 0x20 returns zero. A read in the same cycle as a write to the same register returns the value from before the write.
- R10: All nine `irq` outputs stay 0 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Per-pin output enable |
| wr_err | output | 1 | One-cycle pulse after a dropped set or clear write |
| irq | output | 9 | Interrupt lines, eight for the low pins and one shared; always inactive |

## Verification
The bench targets several corner cases:
- A set or clear word that touches outputs and also input bits. A design that masked the word by direction would leave those input bits unchanged, where they should change.
- A zero word, and words whose bits all fall on input pins. A design that tested only for any written bit would accept these words and miss the error pulse.
- Writes to the edge-control offsets and to unused offsets. A design with a loose decode would corrupt the level or direction register on these writes.
- A read and a write to the direction register in the same cycle. A design with a combinational read path would return the new value instead of the old one.
- A reset in the middle of a test. This checks that level and direction clear while the auxiliary register survives.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam int unsigned OFS_LEVEL = 'h00;
  localparam int unsigned OFS_DIR   = 'h04;
  localparam int unsigned OFS_SET   = 'h08;
  localparam int unsigned OFS_CLR   = 'h0C;
  localparam int unsigned OFS_RISE  = 'h10;
  localparam int unsigned OFS_FALL  = 'h14;
  localparam int unsigned OFS_EDGE  = 'h18;
  localparam int unsigned OFS_AUX   = 'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_EDGE,
    SEL_AUX
  } gpio_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_sel_e         sel
);

  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_LEVEL): sel = SEL_LEVEL;
      ADDR_W'(OFS_DIR):   sel = SEL_DIR;
      ADDR_W'(OFS_SET):   sel = SEL_SET;
      ADDR_W'(OFS_CLR):   sel = SEL_CLR;
      ADDR_W'(OFS_RISE),
      ADDR_W'(OFS_FALL),
      ADDR_W'(OFS_EDGE):  sel = SEL_EDGE;
      ADDR_W'(OFS_AUX):   sel = SEL_AUX;
      default:            sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_level_ctl.sv
module gpio_level_ctl #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] level_q,
  input  logic [DW-1:0] dir_q,
  input  logic [DW-1:0] wdata,
  input  logic          do_set,
  input  logic          do_clr,
  output logic [DW-1:0] level_d,
  output logic          level_en,
  output logic          reject
);

  logic touches_out;

  assign touches_out = |(dir_q & wdata);

  always_comb begin
    level_d  = level_q;
    level_en = 1'b0;
    reject   = 1'b0;
    if (do_set || do_clr) begin
      if (touches_out) begin
        level_en = 1'b1;
        level_d  = do_set ? (level_q | wdata) : (level_q & ~wdata);
      end else begin
        reject = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IRQ_N  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     pin_out,
  output logic [DW-1:0]     pin_oe,
  output logic              wr_err,
  output logic [IRQ_N-1:0]  irq
);

  logic          rst_n_sync;
  gpio_sel_e     sel;
  logic [DW-1:0] level_q, level_d;
  logic          level_en;
  logic [DW-1:0] dir_q, dir_d;
  logic          dir_en;
  logic [DW-1:0] aux_q, aux_d;
  logic          aux_en;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rdata_en;
  logic          err_q, err_d;
  logic          do_set, do_clr;

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign do_set = bus_wr && (sel == SEL_SET);
  assign do_clr = bus_wr && (sel == SEL_CLR);

  gpio_level_ctl #(.DW(DW)) u_level_ctl (
    .level_q  (level_q),
    .dir_q    (dir_q),
    .wdata    (bus_wdata),
    .do_set   (do_set),
    .do_clr   (do_clr),
    .level_d  (level_d),
    .level_en (level_en),
    .reject   (err_d)
  );

  // next-state logic for the plain registers
  always_comb begin
    dir_en   = bus_wr && (sel == SEL_DIR);
    dir_d    = bus_wdata;
    aux_en   = bus_wr && (sel == SEL_AUX);
    aux_d    = bus_wdata;
    rdata_en = bus_rd;
    unique case (sel)
      SEL_LEVEL: rdata_d = level_q;
      SEL_DIR:   rdata_d = dir_q;
      SEL_AUX:   rdata_d = aux_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      level_q <= '0;
      dir_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (level_en) level_q <= level_d;
      if (dir_en)   dir_q   <= dir_d;
      if (rdata_en) rdata_q <= rdata_d;
      err_q <= err_d;
    end
  end

  // auxiliary register deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (aux_en) aux_q <= aux_d;
  end

  generate
    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
      assign irq[i] = 1'b0;
    end
  endgenerate

  assign bus_rdata = rdata_q;
  assign pin_out   = level_q;
  assign pin_oe    = dir_q;
  assign wr_err    = err_q;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [DW-1:0]     pin_out,
  input logic [DW-1:0]     pin_oe,
  input logic              wr_err
);

  logic set_hit, clr_hit, ign_hit, overlap;

  assign set_hit = bus_wr && (bus_addr == ADDR_W'(OFS_SET));
  assign clr_hit = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
  assign ign_hit = bus_wr && ((bus_addr == ADDR_W'(OFS_RISE)) ||
                              (bus_addr == ADDR_W'(OFS_FALL)) ||
                              (bus_addr == ADDR_W'(OFS_EDGE)));
  assign overlap = |(pin_oe & bus_wdata);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == ADDR_W'(OFS_DIR)) |=> pin_oe == $past(bus_wdata));

  // R4
  set_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit && overlap |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  // R5
  clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && overlap |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit || clr_hit) && !overlap |=> wr_err && $stable(pin_out));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((set_hit || clr_hit) && !overlap) |=> !wr_err);

  // R7
  edge_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ign_hit |=> $stable(pin_out) && $stable(pin_oe));

  // R9
  read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == ADDR_W'(OFS_DIR)) |=> bus_rdata == $past(pin_oe));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_regbank gpio_regbank_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .wr_err    (wr_err)
);

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NV = 20;

  typedef struct packed {
    logic          rd;
    logic [7:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   exp_pin;
    logic [31:0]   exp_oe;
    logic          exp_err;
    logic [31:0]   exp_rd;
    logic [7:0]    req;
  } vec_t;

  // rd=1 is a read, rd=0 a write; req names the requirement under test
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h04, 32'h0000_00FF, 32'h0000_0000, 32'h0000_00FF, 1'b0, 32'h0, 8'd2},  // R2
    '{1'b0, 8'h08, 32'h0000_0F0F, 32'h0000_0F0F, 32'h0000_00FF, 1'b0, 32'h0, 8'd4},  // R4
    '{1'b0, 8'h08, 32'hF000_0000, 32'h0000_0F0F, 32'h0000_00FF, 1'b1, 32'h0, 8'd6},  // R6
    '{1'b0, 8'h0C, 32'h0000_0F00, 32'h0000_0F0F, 32'h0000_00FF, 1'b1, 32'h0, 8'd6},  // R6
    '{1'b0, 8'h0C, 32'h0000_0101, 32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd5},  // R5
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd7},  // R7
    '{1'b0, 8'h14, 32'hFFFF_FFFF, 32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd7},  // R7
    '{1'b0, 8'h18, 32'hFFFF_FFFF, 32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd7},  // R7
    '{1'b0, 8'h24, 32'hFFFF_FFFF, 32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd7},  // R7
    '{1'b0, 8'h08, 32'h0000_0000, 32'h0000_0E0E, 32'h0000_00FF, 1'b1, 32'h0, 8'd6},  // R6
    '{1'b1, 8'h00, 32'h0,         32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0000_0E0E, 8'd3}, // R3
    '{1'b1, 8'h04, 32'h0,         32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0000_00FF, 8'd2}, // R2
    '{1'b0, 8'h20, 32'hA5A5_5A5A, 32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd8},  // R8
    '{1'b1, 8'h20, 32'h0,         32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'hA5A5_5A5A, 8'd8}, // R8
    '{1'b1, 8'h0C, 32'h0,         32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd9},  // R9
    '{1'b1, 8'h10, 32'h0,         32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd9},  // R9
    '{1'b1, 8'h02, 32'h0,         32'h0000_0E0E, 32'h0000_00FF, 1'b0, 32'h0, 8'd9},  // R9
    '{1'b0, 8'h04, 32'h0000_FF00, 32'h0000_0E0E, 32'h0000_FF00, 1'b0, 32'h0, 8'd2},  // R2
    '{1'b0, 8'h0C, 32'h0000_F00F, 32'h0000_0E00, 32'h0000_FF00, 1'b0, 32'h0, 8'd5},  // R5
    '{1'b0, 8'h08, 32'hFFFF_0000, 32'h0000_0E00, 32'h0000_FF00, 1'b1, 32'h0, 8'd6}   // R6
  };

  logic          clk;
  logic          rst_n;
  logic          bus_rd;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] pin_out;
  logic [DW-1:0] pin_oe;
  logic          wr_err;
  logic [8:0]    irq;

  int n_chk;
  int n_bad;

  gpio_regbank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .wr_err    (wr_err),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
  endtask

  // drive one access at a falling edge; return at the next falling edge
  task automatic access(input logic rd, input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = rd;
    bus_wr = wr;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    idle();
    do_reset();

    // R1 reset state
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 wr_err", {31'h0, wr_err}, 32'h0);
    check("R10 irq", {23'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].rd, !VEC[i].rd, VEC[i].addr, VEC[i].wdata);
      check($sformatf("R%0d vec%0d pin_out", VEC[i].req, i), pin_out, VEC[i].exp_pin);
      check($sformatf("R%0d vec%0d pin_oe", VEC[i].req, i), pin_oe, VEC[i].exp_oe);
      check($sformatf("R%0d vec%0d wr_err", VEC[i].req, i), {31'h0, wr_err}, {31'h0, VEC[i].exp_err});
      check($sformatf("R10 vec%0d irq", i), {23'h0, irq}, 32'h0);
      if (VEC[i].rd)
        check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp_rd);
      @(negedge clk);
      // R6 error pulse lasts one cycle only
      check($sformatf("R6 vec%0d wr_err clears", i), {31'h0, wr_err}, 32'h0);
    end

    // R9 read and write of the direction register in one cycle
    access(1'b1, 1'b1, 8'h04, 32'h00FF_0000);
    check("R9 read-during-write old value", bus_rdata, 32'h0000_FF00);
    check("R2 new direction", pin_oe, 32'h00FF_0000);
    repeat (3) @(negedge clk);
    check("R9 rdata holds without read", bus_rdata, 32'h0000_FF00);

    // R1 aux survives reset; level and direction clear
    access(1'b0, 1'b1, 8'h20, 32'h1234_5678);
    do_reset();
    check("R1 pin_out after reset", pin_out, 32'h0);
    check("R1 pin_oe after reset", pin_oe, 32'h0);
    access(1'b1, 1'b0, 8'h20, 32'h0);
    check("R1 aux kept through reset", bus_rdata, 32'h1234_5678);
    access(1'b1, 1'b0, 8'h00, 32'h0);
    check("R3 level read after reset", bus_rdata, 32'h0);
    check("R10 irq final", {23'h0, irq}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule